// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupts

This block is a bank of general-purpose I/O pins. Each pin has its own small set of memory-mapped registers. Software uses them to pick the direction, set the driven value, read back the input, and set up interrupt detection. Each input passes through a two-flop synchroniser. A trigger stage then watches it for a level or for a single edge, with a programmable polarity.

Recording a trigger and raising an interrupt are enabled separately. A trigger can set a sticky status bit that software clears by writing a one. Independently, it can request an interrupt on a single summary line. Each pin also carries a routing code. Only pins whose code selects the main processor reach the summary line.

Access is through a plain synchronous port with address, write enable, write data and read data. Read data is registered and appears one cycle after the address.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every pin's direction, output value, interrupt configuration and status are 0, every routing code reads 7, and `summary_irq` is low.
- R2: Bit 9 of a pin's configuration word (0x1000 + 0x10·n) drives `pin_oe[n]`. Bit 1 of its I/O word (0x1004 + 0x10·n) drives `pin_out[n]`. Both outputs change only as a result of a register write.
- R3: Bit 0 of the I/O word reads the pin's input after two register stages. Every read returns its data in the cycle after the address is presented.
- R4: In the interrupt configuration word (0x1008 + 0x10·n), bit 2 = 1 selects edge detection. Bit 1 = 1 then detects only rising edges and bit 1 = 0 only falling edges. A detected edge sets bit 0 of the status word (0x100C + 0x10·n) when bit 3 (status enable) is set.
- R5: With bit 2 = 0 the pin triggers on every cycle its synchronised level equals bit 1. If a trigger and a clearing write land in the same cycle, the status bit stays set.
- R6: Writing 1 to status bit 0 clears that pin's status. Writing 0 leaves it unchanged.
- R7: With status enable clear and interrupt enable (bit 0) set, the status bit never sets, but a trigger still raises `summary_irq`. An edge raises it for one cycle; a level raises it for as long as the level holds.
- R8: `summary_irq` is a registered OR over all pins of (interrupt enable AND routing code (0x0400 + 0x4·n, bits 2:0) equal to 4 AND (status set OR trigger active)). Any other routing code, or interrupt enable clear, keeps the pin off the line.
- R9: Addresses outside the pin words and routing words, including those of pin indices at or beyond the pin count, read as 0, and writes to them change nothing.
- R10: Pins are independent. Clearing one pin's status leaves `summary_irq` high while another pin still qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_out | output | NUM_PINS | Driven output values |
| pin_oe | output | NUM_PINS | Output enables, 1 = drive |
| summary_irq | output | 1 | Combined interrupt to the main processor |

## Verification
The checker assumes the write strobe is low while reset is held. It also assumes every status bit is cleared only through the register port, so any fall in status can be tied to a write one cycle earlier. The bench therefore holds writes quiet during reset and drives inputs and writes only on falling clock edges. It waits several cycles after each pin change, so every edge passes both synchroniser stages before a result is sampled. The one-cycle interrupt pulse of an edge without status enable is sampled at its exact cycle, counted from the input change through the synchroniser and the summary register.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ROUTE_W = 3;

  // bit positions inside the per-pin words
  localparam int OE_BIT   = 9;
  localparam int IN_BIT   = 0;
  localparam int OUT_BIT  = 1;
  localparam int STAT_BIT = 0;

  localparam logic [ROUTE_W-1:0] ROUTE_MAIN = 3'd4;
  localparam logic [ROUTE_W-1:0] ROUTE_NONE = 3'd7;

  // word selector within one pin's 16-byte slot
  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_IO   = 2'd1,
    SEL_ICFG = 2'd2,
    SEL_STAT = 2'd3
  } pin_word_e;

  // interrupt configuration, msb first: status enable, edge, polarity, enable
  typedef struct packed {
    logic raw_en;
    logic det_edge;
    logic pol_high;
    logic irq_en;
  } icfg_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 16,
  parameter int IDX_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              pin_hit,
  output logic [IDX_W-1:0]  pin_idx,
  output pin_word_e         pin_sel,
  output logic              route_hit,
  output logic [IDX_W-1:0]  route_idx
);

  localparam logic [ADDR_W-1:0] PIN_BASE   = ADDR_W'(32'h1000);
  localparam logic [ADDR_W-1:0] PIN_SPAN   = ADDR_W'(NUM_PINS * 16);
  localparam logic [ADDR_W-1:0] ROUTE_BASE = ADDR_W'(32'h0400);
  localparam logic [ADDR_W-1:0] ROUTE_SPAN = ADDR_W'(NUM_PINS * 4);

  logic [ADDR_W-1:0] pin_off;
  logic [ADDR_W-1:0] route_off;

  always_comb begin
    pin_off   = addr - PIN_BASE;
    route_off = addr - ROUTE_BASE;
    pin_hit   = (addr >= PIN_BASE) && (pin_off < PIN_SPAN);
    route_hit = (addr >= ROUTE_BASE) && (route_off < ROUTE_SPAN);
    pin_idx   = pin_off[IDX_W+3:4];
    pin_sel   = pin_word_e'(pin_off[3:2]);
    route_idx = route_off[IDX_W+1:2];
  end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_lvl,
  input  logic               wr_cfg,
  input  logic               wr_io,
  input  logic               wr_icfg,
  input  logic               wr_stat,
  input  logic               wr_route,
  input  logic               wd_oe,
  input  logic               wd_out,
  input  logic [3:0]         wd_icfg,
  input  logic               wd_clr,
  input  logic [ROUTE_W-1:0] wd_route,
  output logic               oe,
  output logic               out,
  output icfg_t              icfg,
  output logic               status,
  output logic [ROUTE_W-1:0] route,
  output logic               irq_req
);

  logic prev_lvl;
  logic edge_hit;
  logic level_hit;
  logic trig;

  always_comb begin
    edge_hit  = icfg.det_edge &&
                (icfg.pol_high ? (in_lvl && !prev_lvl) : (!in_lvl && prev_lvl));
    level_hit = !icfg.det_edge && (in_lvl == icfg.pol_high);
    trig      = edge_hit || level_hit;
    irq_req   = icfg.irq_en && (route == ROUTE_MAIN) && (status || trig);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= 1'b0;
      oe       <= 1'b0;
      out      <= 1'b0;
      icfg     <= '0;
      status   <= 1'b0;
      route    <= ROUTE_NONE;
    end else begin
      prev_lvl <= in_lvl;
      if (wr_cfg)   oe    <= wd_oe;
      if (wr_io)    out   <= wd_out;
      if (wr_icfg)  icfg  <= icfg_t'(wd_icfg);
      if (wr_route) route <= wd_route;
      // a trigger in the same cycle as a clear keeps the bit set
      if (trig && icfg.raw_en)     status <= 1'b1;
      else if (wr_stat && wd_clr)  status <= 1'b0;
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                summary_irq
);

  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [NUM_PINS-1:0] in_sync;
  logic                pin_hit;
  logic                route_hit;
  logic [IDX_W-1:0]    pin_idx;
  logic [IDX_W-1:0]    route_idx;
  pin_word_e           pin_sel;

  logic [NUM_PINS-1:0] stat_vec;
  logic [NUM_PINS-1:0] ie_vec;
  logic [NUM_PINS-1:0] raw_vec;
  logic [NUM_PINS-1:0] route_main_vec;
  logic [NUM_PINS-1:0] irq_vec;
  icfg_t               icfg_arr  [NUM_PINS];
  logic [ROUTE_W-1:0]  route_arr [NUM_PINS];

  logic [DATA_W-1:0]   rd_next;
  logic                unused_bits;

  assign unused_bits = ^{reg_wdata[DATA_W-1:OE_BIT+1], reg_wdata[OE_BIT-1:4]};

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (in_sync)
  );

  gpio_addr_decode #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W)
  ) u_dec (
    .addr      (reg_addr),
    .pin_hit   (pin_hit),
    .pin_idx   (pin_idx),
    .pin_sel   (pin_sel),
    .route_hit (route_hit),
    .route_idx (route_idx)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic sel_me;
    logic rsel_me;
    assign sel_me  = reg_wr && pin_hit && (pin_idx == IDX_W'(i));
    assign rsel_me = reg_wr && route_hit && (route_idx == IDX_W'(i));

    gpio_pin_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .in_lvl   (in_sync[i]),
      .wr_cfg   (sel_me && (pin_sel == SEL_CFG)),
      .wr_io    (sel_me && (pin_sel == SEL_IO)),
      .wr_icfg  (sel_me && (pin_sel == SEL_ICFG)),
      .wr_stat  (sel_me && (pin_sel == SEL_STAT)),
      .wr_route (rsel_me),
      .wd_oe    (reg_wdata[OE_BIT]),
      .wd_out   (reg_wdata[OUT_BIT]),
      .wd_icfg  (reg_wdata[3:0]),
      .wd_clr   (reg_wdata[STAT_BIT]),
      .wd_route (reg_wdata[ROUTE_W-1:0]),
      .oe       (pin_oe[i]),
      .out      (pin_out[i]),
      .icfg     (icfg_arr[i]),
      .status   (stat_vec[i]),
      .route    (route_arr[i]),
      .irq_req  (irq_vec[i])
    );

    assign ie_vec[i]         = icfg_arr[i].irq_en;
    assign raw_vec[i]        = icfg_arr[i].raw_en;
    assign route_main_vec[i] = (route_arr[i] == ROUTE_MAIN);
  end

  always_comb begin
    rd_next = '0;
    if (pin_hit) begin
      unique case (pin_sel)
        SEL_CFG:  rd_next[OE_BIT] = pin_oe[pin_idx];
        SEL_IO: begin
          rd_next[IN_BIT]  = in_sync[pin_idx];
          rd_next[OUT_BIT] = pin_out[pin_idx];
        end
        SEL_ICFG: rd_next[3:0] = icfg_arr[pin_idx];
        SEL_STAT: rd_next[STAT_BIT] = stat_vec[pin_idx];
        default:  rd_next = '0;
      endcase
    end else if (route_hit) begin
      rd_next[ROUTE_W-1:0] = route_arr[route_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata   <= '0;
      summary_irq <= 1'b0;
    end else begin
      reg_rdata   <= rd_next;
      summary_irq <= |irq_vec;
    end
  end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_wr,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_out,
  input logic                summary_irq,
  input logic [NUM_PINS-1:0] stat_vec,
  input logic [NUM_PINS-1:0] ie_vec,
  input logic [NUM_PINS-1:0] raw_vec,
  input logic [NUM_PINS-1:0] route_main_vec
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!summary_irq && pin_oe == '0 && pin_out == '0)); // R1

  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_wr) |-> $stable(pin_oe)); // R2

  AST_OUT_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_wr) |-> $stable(pin_out)); // R2

  AST_STATUS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ((stat_vec & ~$past(stat_vec) & ~$past(raw_vec)) == '0)); // R7

  AST_STATUS_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (|($past(stat_vec) & ~stat_vec)) |-> $past(reg_wr)); // R6

  AST_SUMMARY_ROUTED: assert property (@(posedge clk) disable iff (rst)
    summary_irq |-> $past(|(ie_vec & route_main_vec))); // R8

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .reg_wr         (reg_wr),
  .pin_oe         (pin_oe),
  .pin_out        (pin_out),
  .summary_irq    (summary_irq),
  .stat_vec       (stat_vec),
  .ie_vec         (ie_vec),
  .raw_vec        (raw_vec),
  .route_main_vec (route_main_vec)
);

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out;
  logic [N-1:0] pin_oe;
  logic        summary_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          rd_issued = 0;
  bit          rd_live   = 0;

  always #2 clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(N)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .summary_irq(summary_irq)
  );

  function automatic logic [15:0] a_cfg(int n);   return 16'(32'h1000 + 16*n); endfunction
  function automatic logic [15:0] a_io(int n);    return 16'(32'h1004 + 16*n); endfunction
  function automatic logic [15:0] a_icfg(int n);  return 16'(32'h1008 + 16*n); endfunction
  function automatic logic [15:0] a_stat(int n);  return 16'(32'h100C + 16*n); endfunction
  function automatic logic [15:0] a_route(int n); return 16'(32'h0400 + 4*n);  endfunction

  task automatic compare(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: read data arrives the cycle after the address
  always @(posedge clk) rd_live <= rd_issued;
  always @(negedge clk) begin
    if (rd_live && exp_q.size() > 0)
      compare(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
  end

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a; rd_issued = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_issued = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic chk_irq(logic exp, string tag);
    compare(tag, {31'b0, summary_irq}, {31'b0, exp});
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1 summary after reset");
    compare("R1 oe after reset", {24'b0, pin_oe}, 32'h0);
    rd(a_cfg(0),   32'h0, "R1 cfg reset");
    rd(a_icfg(5),  32'h0, "R1 icfg reset");
    rd(a_stat(7),  32'h0, "R1 status reset");
    rd(a_route(3), 32'h7, "R1 route reset");

    // R2 direction and output
    wr(a_cfg(2), 32'h200);
    wr(a_io(2),  32'h2);
    @(negedge clk);
    compare("R2 pin_oe", {24'b0, pin_oe}, 32'h4);
    compare("R2 pin_out", {24'b0, pin_out}, 32'h4);
    rd(a_cfg(2), 32'h200, "R2 cfg readback");
    rd(a_io(2),  32'h2,   "R2 io readback");

    // R3 input readback
    pin_in[3] = 1'b1; settle();
    rd(a_io(3), 32'h1, "R3 input high");
    pin_in[3] = 1'b0; settle();
    rd(a_io(3), 32'h0, "R3 input low");

    // R4 rising edge with status enable
    wr(a_route(1), 32'h4);
    wr(a_icfg(1),  32'hF);
    pin_in[1] = 1'b1; settle();
    chk_irq(1'b1, "R4 summary on rise");
    rd(a_stat(1), 32'h1, "R4 status on rise");
    pin_in[1] = 1'b0; settle();
    rd(a_stat(1), 32'h1, "R4 status sticky");
    wr(a_stat(1), 32'h0); settle();
    rd(a_stat(1), 32'h1, "R6 write zero no effect");
    wr(a_stat(1), 32'h1); settle();
    rd(a_stat(1), 32'h0, "R6 write one clears");
    chk_irq(1'b0, "R6 summary after clear");
    // R4 falling edge polarity
    wr(a_icfg(1), 32'hD);
    pin_in[1] = 1'b1; settle();
    rd(a_stat(1), 32'h0, "R4 rise ignored in falling mode");
    chk_irq(1'b0, "R4 no summary on rise in falling mode");
    pin_in[1] = 1'b0; settle();
    rd(a_stat(1), 32'h1, "R4 status on fall");
    chk_irq(1'b1, "R4 summary on fall");
    wr(a_stat(1), 32'h1); settle();

    // R5 level trigger, set wins over clear
    wr(a_route(4), 32'h4);
    wr(a_icfg(4),  32'hB);
    pin_in[4] = 1'b1; settle();
    rd(a_stat(4), 32'h1, "R5 level status");
    chk_irq(1'b1, "R5 level summary");
    wr(a_stat(4), 32'h1); settle();
    rd(a_stat(4), 32'h1, "R5 set wins over clear");
    pin_in[4] = 1'b0; settle();
    chk_irq(1'b1, "R5 status holds summary");
    wr(a_stat(4), 32'h1); settle();
    rd(a_stat(4), 32'h0, "R5 cleared after level gone");
    chk_irq(1'b0, "R5 summary low");

    // R7 status enable off
    wr(a_route(5), 32'h4);
    wr(a_icfg(5),  32'h3);
    pin_in[5] = 1'b1; settle();
    chk_irq(1'b1, "R7 level raises summary");
    rd(a_stat(5), 32'h0, "R7 no status on level");
    pin_in[5] = 1'b0; settle();
    chk_irq(1'b0, "R7 summary drops with level");
    wr(a_icfg(5), 32'h7); settle();
    pin_in[5] = 1'b1;
    repeat (3) @(negedge clk);
    chk_irq(1'b1, "R7 edge pulse cycle");
    @(negedge clk);
    chk_irq(1'b0, "R7 edge pulse ends");
    rd(a_stat(5), 32'h0, "R7 no status on edge");

    // R8 routing and enable gate
    wr(a_icfg(6), 32'hF);
    pin_in[6] = 1'b1; settle();
    rd(a_stat(6), 32'h1, "R8 status with route none");
    chk_irq(1'b0, "R8 route 7 blocks");
    wr(a_route(6), 32'h4); settle();
    chk_irq(1'b1, "R8 route 4 passes");
    wr(a_route(6), 32'h5); settle();
    chk_irq(1'b0, "R8 route 5 blocks");
    wr(a_stat(6), 32'h1); settle();
    wr(a_route(7), 32'h4);
    wr(a_icfg(7),  32'hE);
    pin_in[7] = 1'b1; settle();
    rd(a_stat(7), 32'h1, "R8 status without enable");
    chk_irq(1'b0, "R8 enable clear blocks");
    wr(a_stat(7), 32'h1); settle();

    // R10 independent pins
    wr(a_route(0), 32'h4);
    wr(a_icfg(0),  32'hF);
    wr(a_route(3), 32'h4);
    wr(a_icfg(3),  32'hF);
    pin_in[0] = 1'b1; pin_in[3] = 1'b1; settle();
    chk_irq(1'b1, "R10 two pins pending");
    wr(a_stat(0), 32'h1); settle();
    rd(a_stat(0), 32'h0, "R10 pin0 cleared");
    rd(a_stat(3), 32'h1, "R10 pin3 still set");
    chk_irq(1'b1, "R10 summary held by other pin");
    wr(a_stat(3), 32'h1); settle();
    chk_irq(1'b0, "R10 summary after both cleared");

    // R9 unmapped addresses
    wr(16'(32'h1000 + 16*N), 32'h200);
    wr(16'(32'h0400 + 4*N),  32'h4);
    @(negedge clk);
    compare("R9 oe unchanged", {24'b0, pin_oe}, 32'h4);
    rd(16'(32'h1000 + 16*N), 32'h0, "R9 out of range pin reads zero");
    rd(16'(32'h0400 + 4*N),  32'h0, "R9 out of range route reads zero");
    rd(16'h2000, 32'h0, "R9 unmapped reads zero");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R3: actual %0d reads outstanding expected 0", exp_q.size());
    end
    done = 1;
    report();
    $finish;
  end

endmodule